// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block sits between a synchronous host and an asynchronous static RAM array of 128K words by 32 bits. The array is four 8-bit lanes. Each lane has its own active-low chip select and its own active-low write enable. All lanes share one active-low output enable and a 17-bit word address. The host issues one request per handshake: a direction, an address, write data, a byte mask and a width mode. The controller then produces registered strobes whose durations come from nanosecond timing parameters, each rounded up to whole clocks of the configured period. Read data comes back with a one-clock valid pulse.

The width mode lets software treat the same array as 32-, 16- or 8-bit memory. In the narrow modes, the low host address bits pick the lane pair or the single lane. Write data is replicated across the lanes, and read data is shifted down to the low bits. A write runs through four phases: address setup, write pulse, strobe release and hold. A read keeps its chip selects and the output enable low for the access window. After every read, a turnaround window follows in which the data bus is left undriven.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, every `ram_cs_n` and `ram_we_n` bit is 1, `ram_oe_n` is 1, `ram_dq_oe` is 0 and `rd_valid` is 0.
- R2: A request is taken on a clock edge where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the next clock until the cycle ends, and it is always 0 while any chip select is low.
- R3: In a write, the chip selects of the enabled lanes go low on the clock after acceptance. Their write enables go low NAS clocks later and stay low for exactly NWP clocks. A write enable is never low while its chip select is high. NAS = max(1, ceil(tAS/T)) and NWP = max(1, ceil(tWP/T), ceil(tDW/T), ceil(tCW/T)-NAS, ceil(tAW/T)-NAS), where T is the clock period.
- R4: Write data is driven (`ram_dq_oe`=1) from the first write-enable-low clock through the release clock and NHOLD hold clocks. Address and data stay stable while they are driven. `req_ready` returns NAS+NWP+1+NHOLD clocks after acceptance, with NHOLD = max(1, ceil(tAH/T), ceil(tWC/T)-NAS-NWP-1).
- R5: A read holds the addressed lanes' chip selects and `ram_oe_n` low, with all write enables high, for NRD = max(1, ceil(tRC/T), ceil(tAA/T), ceil(tOE/T)) clocks. It then captures the bus, and `rd_valid` is high for exactly one clock with `rd_data`, NRD clocks after acceptance.
- R6: After a read releases its strobes, the controller waits NTA = max(1, ceil(max(tOHZ,tCHZ)/T)) clocks with the bus undriven before `req_ready` returns. The bus is never driven sooner than NTA clocks after `ram_oe_n` rises.
- R7: The output enable and any write enable are never low together, and `ram_dq_oe` is never 1 while `ram_oe_n` is 0.
- R8: Mode 2'b00 (and 2'b11, which behaves the same) is 32-bit. The word address is host address bits 16:0. Write lanes follow `req_mask` bit n for lane n (data bits 8n+7:8n), reads enable all four lanes, and data is not shifted.
- R9: Mode 2'b01 is 16-bit. The word address is host address bits 17:1, and host address bit 0 picks lanes 3:2 (1) or lanes 1:0 (0). `req_mask[1:0]` enables the pair's low and high lane, write data bits 15:0 are driven on both halves, and read data from the chosen pair returns in `rd_data[15:0]` with the upper bits zero.
- R10: Mode 2'b10 is 8-bit. The word address is host address bits 18:2, and host address bits 1:0 pick a single lane. `req_mask[0]` enables the write, write data bits 7:0 are driven on all four lanes, and the read byte returns in `rd_data[7:0]` with the upper bits zero.
- R11: A write whose effective lane mask is zero asserts no write enable and no chip select, leaves memory unchanged, and still completes with normal `req_ready` timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Host address in units of the selected width |
| req_wdata | input | 32 | Write data, low-aligned in narrow modes |
| req_mask | input | 4 | Byte enables for writes |
| req_mode | input | 2 | 00/11 = 32-bit, 01 = 16-bit, 10 = 8-bit |
| rd_valid | output | 1 | One-clock pulse with read data |
| rd_data | output | 32 | Read data, low-aligned in narrow modes |
| ram_addr | output | 17 | Word address to the RAM |
| ram_cs_n | output | 4 | Per-lane chip select, active low |
| ram_we_n | output | 4 | Per-lane write enable, active low |
| ram_oe_n | output | 1 | Shared output enable, active low |
| ram_dq_out | output | 32 | Data driven toward the RAM |
| ram_dq_oe | output | 1 | Drive enable for the data bus |
| ram_dq_in | input | 32 | Data returned by the RAM |

## Verification
The bench uses the default parameters: an 8 ns clock and the fastest timing grade. That gives NAS=1, NWP=7, NHOLD=1, NRD=9 and NTA=4, so every phase count lies on an exact rounding boundary. A strobe window that is one clock short then moves an observed edge. The bench's RAM model returns filler bytes until the access time has elapsed, so a read that samples too early returns wrong data. Lane steering is exercised with distinct word addresses and data patterns in all four modes, with partial masks and with an empty mask.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int LANE_W   = 8;
    localparam int N_LANES  = 4;
    localparam int DATA_W   = LANE_W * N_LANES;
    localparam int WADDR_W  = 17;
    localparam int HADDR_W  = WADDR_W + 2;
    localparam int SLOT_W   = $clog2(N_LANES);
    localparam int HALF_W   = DATA_W / 2;
    localparam int HALF_L   = N_LANES / 2;

    typedef enum logic [1:0] {
        MODE_W32  = 2'b00,
        MODE_W16  = 2'b01,
        MODE_W8   = 2'b10,
        MODE_W32B = 2'b11
    } width_mode_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_WSETUP,
        PH_WPULSE,
        PH_WREL,
        PH_WHOLD,
        PH_RACC,
        PH_TURN
    } phase_e;

    typedef struct packed {
        logic                 is_write;
        logic [HADDR_W-1:0]   addr;
        logic [DATA_W-1:0]    wdata;
        logic [N_LANES-1:0]   mask;
        width_mode_e          mode;
    } host_req_t;

    typedef struct packed {
        logic                 is_write;
        logic [WADDR_W-1:0]   word;
        logic [N_LANES-1:0]   lanes;
        logic [DATA_W-1:0]    wdata;
        logic [SLOT_W-1:0]    slot;
        width_mode_e          mode;
    } lane_cmd_t;

    function automatic int clk_ceil(input int ns, input int per);
        return (ns + per - 1) / per;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int setup_clocks(input int per, input int t_as);
        return max2(1, clk_ceil(t_as, per));
    endfunction

    function automatic int pulse_clocks(input int per, input int t_as, input int t_wp,
                                        input int t_dw, input int t_cw, input int t_aw);
        int n_as;
        n_as = setup_clocks(per, t_as);
        return max2(max2(1, clk_ceil(t_wp, per)),
                    max2(clk_ceil(t_dw, per),
                         max2(clk_ceil(t_cw, per) - n_as, clk_ceil(t_aw, per) - n_as)));
    endfunction

    function automatic int turn_clocks(input int per, input int t_ohz, input int t_chz);
        return max2(1, clk_ceil(max2(t_ohz, t_chz), per));
    endfunction

endpackage

// File: rtl/sram_lane_steer.sv
module sram_lane_steer
    import sram_lane_pkg::*;
(
    input  host_req_t req,
    output lane_cmd_t cmd
);
    logic [N_LANES-1:0] pair_base;
    logic [N_LANES-1:0] one_lane;
    logic [N_LANES-1:0] rd_lanes;
    logic [N_LANES-1:0] wr_lanes;

    assign pair_base = {{HALF_L{1'b0}}, {HALF_L{1'b1}}};
    assign one_lane  = N_LANES'(1) << req.addr[SLOT_W-1:0];

    always_comb begin
        cmd          = '0;
        cmd.is_write = req.is_write;
        cmd.mode     = req.mode;
        rd_lanes     = '1;
        wr_lanes     = req.mask;
        unique case (req.mode)
            MODE_W16: begin
                cmd.word  = req.addr[WADDR_W:1];
                cmd.slot  = SLOT_W'(req.addr[0]);
                cmd.wdata = {2{req.wdata[HALF_W-1:0]}};
                if (req.addr[0]) begin
                    rd_lanes = pair_base << HALF_L;
                    wr_lanes = {req.mask[HALF_L-1:0], {HALF_L{1'b0}}};
                end else begin
                    rd_lanes = pair_base;
                    wr_lanes = {{HALF_L{1'b0}}, req.mask[HALF_L-1:0]};
                end
            end
            MODE_W8: begin
                cmd.word  = req.addr[WADDR_W+1:2];
                cmd.slot  = req.addr[SLOT_W-1:0];
                cmd.wdata = {N_LANES{req.wdata[LANE_W-1:0]}};
                rd_lanes  = one_lane;
                wr_lanes  = req.mask[0] ? one_lane : '0;
            end
            default: begin
                cmd.word  = req.addr[WADDR_W-1:0];
                cmd.slot  = '0;
                cmd.wdata = req.wdata;
            end
        endcase
        cmd.lanes = req.is_write ? wr_lanes : rd_lanes;
    end

endmodule

// File: rtl/sram_lane_align.sv
module sram_lane_align
    import sram_lane_pkg::*;
(
    input  width_mode_e          mode,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [DATA_W-1:0]    raw,
    output logic [DATA_W-1:0]    aligned
);
    always_comb begin
        unique case (mode)
            MODE_W16: aligned = slot[0] ? DATA_W'(raw[DATA_W-1:HALF_W])
                                        : DATA_W'(raw[HALF_W-1:0]);
            MODE_W8:  aligned = DATA_W'(raw[slot*LANE_W +: LANE_W]);
            default:  aligned = raw;
        endcase
    end

endmodule

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_WC  = 70,
    parameter int T_AS  = 5,
    parameter int T_AH  = 5,
    parameter int T_WP  = 50,
    parameter int T_DW  = 30,
    parameter int T_CW  = 60,
    parameter int T_AW  = 60,
    parameter int T_RC  = 70,
    parameter int T_AA  = 70,
    parameter int T_OE  = 35,
    parameter int T_OHZ = 25,
    parameter int T_CHZ = 25
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [HADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [N_LANES-1:0]   req_mask,
    input  logic [1:0]           req_mode,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [WADDR_W-1:0]   ram_addr,
    output logic [N_LANES-1:0]   ram_cs_n,
    output logic [N_LANES-1:0]   ram_we_n,
    output logic                 ram_oe_n,
    output logic [DATA_W-1:0]    ram_dq_out,
    output logic                 ram_dq_oe,
    input  logic [DATA_W-1:0]    ram_dq_in
);
    localparam int P      = CLK_PERIOD_NS;
    localparam int N_AS   = setup_clocks(P, T_AS);
    localparam int N_WP   = pulse_clocks(P, T_AS, T_WP, T_DW, T_CW, T_AW);
    localparam int N_HOLD = max2(max2(1, clk_ceil(T_AH, P)), clk_ceil(T_WC, P) - N_AS - N_WP - 1);
    localparam int N_RD   = max2(max2(1, clk_ceil(T_RC, P)), max2(clk_ceil(T_AA, P), clk_ceil(T_OE, P)));
    localparam int N_TA   = turn_clocks(P, T_OHZ, T_CHZ);
    localparam int N_MAX  = max2(max2(N_AS, N_WP), max2(max2(N_HOLD, N_RD), N_TA));
    localparam int CNT_W  = $clog2(N_MAX + 1);

    host_req_t          hreq;
    lane_cmd_t          cmd_new;
    lane_cmd_t          cmd_q;
    phase_e             phase;
    phase_e             phase_nx;
    logic               accept;
    logic               advance;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_expired;
    logic [DATA_W-1:0]  rd_aligned;

    assign hreq.is_write = req_write;
    assign hreq.addr     = req_addr;
    assign hreq.wdata    = req_wdata;
    assign hreq.mask     = req_mask;
    assign hreq.mode     = width_mode_e'(req_mode);

    sram_lane_steer u_steer (
        .req (hreq),
        .cmd (cmd_new)
    );

    sram_lane_align u_align (
        .mode    (cmd_q.mode),
        .slot    (cmd_q.slot),
        .raw     (ram_dq_in),
        .aligned (rd_aligned)
    );

    sram_lane_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign accept = req_valid && req_ready;

    always_comb begin
        advance  = 1'b0;
        phase_nx = phase;
        tmr_val  = '0;
        unique case (phase)
            PH_IDLE: begin
                advance = accept;
                if (req_write) begin
                    phase_nx = PH_WSETUP;
                    tmr_val  = CNT_W'(N_AS - 1);
                end else begin
                    phase_nx = PH_RACC;
                    tmr_val  = CNT_W'(N_RD - 1);
                end
            end
            PH_WSETUP: begin
                advance  = tmr_expired;
                phase_nx = PH_WPULSE;
                tmr_val  = CNT_W'(N_WP - 1);
            end
            PH_WPULSE: begin
                advance  = tmr_expired;
                phase_nx = PH_WREL;
            end
            PH_WREL: begin
                advance  = 1'b1;
                phase_nx = PH_WHOLD;
                tmr_val  = CNT_W'(N_HOLD - 1);
            end
            PH_WHOLD: begin
                advance  = tmr_expired;
                phase_nx = PH_IDLE;
            end
            PH_RACC: begin
                advance  = tmr_expired;
                phase_nx = PH_TURN;
                tmr_val  = CNT_W'(N_TA - 1);
            end
            PH_TURN: begin
                advance  = tmr_expired;
                phase_nx = PH_IDLE;
            end
            default: begin
                advance  = 1'b1;
                phase_nx = PH_IDLE;
            end
        endcase
        tmr_load = advance;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cmd_q      <= '0;
            req_ready  <= 1'b1;
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            ram_addr   <= '0;
            ram_cs_n   <= '1;
            ram_we_n   <= '1;
            ram_oe_n   <= 1'b1;
            ram_dq_out <= '0;
            ram_dq_oe  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (advance) begin
                phase <= phase_nx;
                unique case (phase)
                    PH_IDLE: begin
                        cmd_q     <= cmd_new;
                        ram_addr  <= cmd_new.word;
                        ram_cs_n  <= ~cmd_new.lanes;
                        ram_oe_n  <= cmd_new.is_write;
                        req_ready <= 1'b0;
                    end
                    PH_WSETUP: begin
                        ram_we_n   <= ~cmd_q.lanes;
                        ram_dq_out <= cmd_q.wdata;
                        ram_dq_oe  <= 1'b1;
                    end
                    PH_WPULSE: begin
                        ram_we_n <= '1;
                    end
                    PH_WREL: begin
                        ram_cs_n <= '1;
                    end
                    PH_WHOLD: begin
                        ram_dq_oe <= 1'b0;
                        req_ready <= 1'b1;
                    end
                    PH_RACC: begin
                        rd_data  <= rd_aligned;
                        rd_valid <= 1'b1;
                        ram_cs_n <= '1;
                        ram_oe_n <= 1'b1;
                    end
                    PH_TURN: begin
                        req_ready <= 1'b1;
                    end
                    default: begin
                        ram_cs_n  <= '1;
                        ram_we_n  <= '1;
                        ram_oe_n  <= 1'b1;
                        ram_dq_oe <= 1'b0;
                        req_ready <= 1'b1;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk
    import sram_lane_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_AS  = 5,
    parameter int T_WP  = 50,
    parameter int T_DW  = 30,
    parameter int T_CW  = 60,
    parameter int T_AW  = 60,
    parameter int T_OHZ = 25,
    parameter int T_CHZ = 25
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_ready,
    input logic                 rd_valid,
    input logic [WADDR_W-1:0]   ram_addr,
    input logic [N_LANES-1:0]   ram_cs_n,
    input logic [N_LANES-1:0]   ram_we_n,
    input logic                 ram_oe_n,
    input logic [DATA_W-1:0]    ram_dq_out,
    input logic                 ram_dq_oe
);
    localparam int C_WP = pulse_clocks(CLK_PERIOD_NS, T_AS, T_WP, T_DW, T_CW, T_AW);
    localparam int C_TA = turn_clocks(CLK_PERIOD_NS, T_OHZ, T_CHZ);
    localparam int CW   = $clog2(max2(C_WP, C_TA) + 2) + 1;

    logic [CW-1:0] we_low_cnt;
    logic [CW-1:0] oe_high_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt  <= '0;
            oe_high_cnt <= CW'(C_TA);
        end else begin
            if (ram_we_n != '1) we_low_cnt <= we_low_cnt + 1'b1;
            else                we_low_cnt <= '0;
            if (!ram_oe_n)                 oe_high_cnt <= '0;
            else if (oe_high_cnt < CW'(C_TA)) oe_high_cnt <= oe_high_cnt + 1'b1;
        end
    end

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (ram_cs_n != '1) |-> !req_ready);

    p_we_inside_cs_r3: assert property (@(posedge clk) disable iff (rst)
        ((~ram_we_n) & ram_cs_n) == '0);

    p_we_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(&ram_we_n) |-> (we_low_cnt >= CW'(C_WP)));

    p_drive_stable_r4: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |=> (!ram_dq_oe || ($stable(ram_dq_out) && $stable(ram_addr))));

    p_addr_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (ram_cs_n != '1) |=> ((ram_cs_n == '1) || $stable(ram_addr)));

    p_rd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ram_dq_oe) |-> (oe_high_cnt >= CW'(C_TA)));

    p_oe_we_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(!ram_oe_n && (ram_we_n != '1)));

    p_no_drive_read_r7: assert property (@(posedge clk) disable iff (rst)
        ram_dq_oe |-> ram_oe_n);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_AS  (T_AS),
    .T_WP  (T_WP),
    .T_DW  (T_DW),
    .T_CW  (T_CW),
    .T_AW  (T_AW),
    .T_OHZ (T_OHZ),
    .T_CHZ (T_CHZ)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .ram_addr   (ram_addr),
    .ram_cs_n   (ram_cs_n),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb_top;

    localparam int TCLK  = 8;
    localparam int E_AS  = 1;   // ceil(5/8)
    localparam int E_WP  = 7;   // ceil(50/8), ceil(60/8)-1
    localparam int E_HD  = 1;   // max(ceil(5/8), 9-1-7-1)
    localparam int E_RD  = 9;   // ceil(70/8)
    localparam int E_TA  = 4;   // ceil(25/8)
    localparam int E_WRDY = E_AS + E_WP + 1 + E_HD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_mask = '0;
    logic [1:0]  req_mode = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [16:0] ram_addr;
    logic [3:0]  ram_cs_n;
    logic [3:0]  ram_we_n;
    logic        ram_oe_n;
    logic [31:0] ram_dq_out;
    logic        ram_dq_oe;
    logic [31:0] ram_dq_in = 32'hEEEE_EEEE;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(TCLK/2) clk = ~clk;

    sram_lane_ctrl dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .req_mode(req_mode), .rd_valid(rd_valid), .rd_data(rd_data),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
        .ram_dq_in(ram_dq_in)
    );

    // RAM model: data valid only once the access time has elapsed
    logic [31:0] mem [int];
    int oe_cnt = 0;
    int contention = 0;

    always @(negedge clk) begin
        logic [31:0] w;
        w = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 32'h0;
        for (int i = 0; i < 4; i++) begin
            if (!ram_cs_n[i] && !ram_we_n[i] && ram_dq_oe)
                w[i*8 +: 8] = ram_dq_out[i*8 +: 8];
        end
        mem[int'(ram_addr)] = w;
        if (!ram_oe_n) oe_cnt++; else oe_cnt = 0;
        if (ram_dq_oe && !ram_oe_n) contention++;
        for (int i = 0; i < 4; i++) begin
            if (!ram_cs_n[i] && !ram_oe_n && ram_we_n[i] && oe_cnt * TCLK >= 70)
                ram_dq_in[i*8 +: 8] <= w[i*8 +: 8];
            else
                ram_dq_in[i*8 +: 8] <= 8'hEE;
        end
    end

    int          cs_first, we_first, we_cnt, rd_k, ready_k, oe_last, drv_bad;
    logic [3:0]  lanes_seen, we_lanes;
    logic [16:0] addr_seen;
    logic [31:0] wd_seen, rd_seen;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input bit wr, input logic [18:0] a, input logic [31:0] d,
                          input logic [3:0] m, input logic [1:0] md);
        cs_first = -1; we_first = -1; we_cnt = 0; rd_k = -1; ready_k = -1;
        oe_last = -1; drv_bad = 0; lanes_seen = '0; we_lanes = '0;
        addr_seen = '0; wd_seen = '0; rd_seen = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a;
        req_wdata = d; req_mask = m; req_mode = md;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            if (ram_cs_n != '1) begin
                if (cs_first < 0) begin cs_first = k; addr_seen = ram_addr; end
                lanes_seen |= ~ram_cs_n;
            end
            if (ram_we_n != '1) begin
                if (we_first < 0) we_first = k;
                we_cnt++;
                we_lanes |= ~ram_we_n;
                wd_seen = ram_dq_out;
                if (!ram_dq_oe) drv_bad++;
            end
            if (ram_dq_oe) oe_last = k;
            if (rd_valid) begin rd_k = k; rd_seen = rd_data; end
            if (req_ready) begin ready_k = k; break; end
        end
    endtask

    task automatic t_reset;
        chk(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
        chk(ram_cs_n === 4'hF && ram_we_n === 4'hF, "R1", "cs/we idle",
            {ram_cs_n, ram_we_n}, 32'hFF);
        chk(ram_oe_n === 1'b1 && ram_dq_oe === 1'b0 && rd_valid === 1'b0, "R1",
            "oe/drive/valid idle", {ram_oe_n, ram_dq_oe, rd_valid}, 32'h4);
    endtask

    task automatic t_write32;
        run_op(1'b1, 19'h00123, 32'hA1B2_C3D4, 4'hF, 2'b00);
        chk(cs_first == 0, "R3", "cs low clock", cs_first, 0);
        chk(we_first == E_AS, "R3", "we low after setup", we_first, E_AS);
        chk(we_cnt == E_WP, "R3", "we pulse width", we_cnt, E_WP);
        chk(ready_k == E_WRDY, "R2", "ready return on write", ready_k, E_WRDY);
        chk(oe_last == E_WRDY - 1 && drv_bad == 0, "R4", "data drive window",
            oe_last, E_WRDY - 1);
        chk(wd_seen == 32'hA1B2_C3D4, "R4", "write data", wd_seen, 32'hA1B2_C3D4);
        chk(addr_seen == 17'h00123 && we_lanes == 4'hF, "R8", "32-bit addr/lanes",
            {addr_seen, 11'h0, we_lanes}, {17'h00123, 11'h0, 4'hF});
    endtask

    task automatic t_read32(input logic [16:0] w, input logic [31:0] exp, input string req);
        run_op(1'b0, {2'b00, w}, 32'h0, 4'h0, 2'b00);
        chk(rd_k == E_RD, "R5", "read valid clock", rd_k, E_RD);
        chk(rd_seen == exp, req, "32-bit read data", rd_seen, exp);
        chk(ready_k - rd_k == E_TA, "R6", "turnaround length", ready_k - rd_k, E_TA);
        chk(lanes_seen == 4'hF && we_cnt == 0, "R5", "read lanes, no write strobe",
            {lanes_seen, 4'(we_cnt)}, 32'hF0);
    endtask

    task automatic t_partial32;
        run_op(1'b1, 19'h00123, 32'h1122_3344, 4'b0101, 2'b00);
        chk(we_lanes == 4'b0101, "R8", "masked write lanes", we_lanes, 4'b0101);
        t_read32(17'h00123, 32'hA122_C344, "R8");
    endtask

    task automatic t_mode16;
        run_op(1'b1, {1'b0, 17'h00456, 1'b1}, 32'h0000_BEEF, 4'b0011, 2'b01);
        chk(addr_seen == 17'h00456 && lanes_seen == 4'b1100, "R9", "16-bit addr/lanes",
            {addr_seen, 11'h0, lanes_seen}, {17'h00456, 11'h0, 4'hC});
        chk(wd_seen == 32'hBEEF_BEEF, "R9", "16-bit replicated data", wd_seen, 32'hBEEF_BEEF);
        run_op(1'b0, {1'b0, 17'h00456, 1'b1}, 32'h0, 4'h0, 2'b01);
        chk(rd_seen == 32'h0000_BEEF, "R9", "16-bit read shifted", rd_seen, 32'h0000_BEEF);
        chk(lanes_seen == 4'b1100, "R9", "16-bit read lanes", lanes_seen, 4'hC);
        t_read32(17'h00456, 32'hBEEF_0000, "R9");
    endtask

    task automatic t_mode8;
        run_op(1'b1, {17'h00789, 2'b10}, 32'h0000_005A, 4'b0001, 2'b10);
        chk(addr_seen == 17'h00789 && we_lanes == 4'b0100, "R10", "8-bit addr/lane",
            {addr_seen, 11'h0, we_lanes}, {17'h00789, 11'h0, 4'h4});
        chk(wd_seen == 32'h5A5A_5A5A, "R10", "8-bit replicated data", wd_seen, 32'h5A5A_5A5A);
        run_op(1'b0, {17'h00789, 2'b10}, 32'h0, 4'h0, 2'b10);
        chk(rd_seen == 32'h0000_005A, "R10", "8-bit read shifted", rd_seen, 32'h0000_005A);
        t_read32(17'h00789, 32'h005A_0000, "R10");
    endtask

    task automatic t_empty_mask;
        run_op(1'b1, 19'h00123, 32'hFFFF_FFFF, 4'h0, 2'b00);
        chk(we_first == -1 && cs_first == -1, "R11", "no strobes on empty mask",
            {we_first[15:0], cs_first[15:0]}, 32'hFFFF_FFFF);
        chk(ready_k == E_WRDY, "R11", "empty write completes", ready_k, E_WRDY);
        t_read32(17'h00123, 32'hA122_C344, "R11");
    endtask

    task automatic t_mode11;
        run_op(1'b0, 19'h00123, 32'h0, 4'h0, 2'b11);
        chk(rd_seen == 32'hA122_C344 && lanes_seen == 4'hF, "R8", "mode 11 as 32-bit",
            rd_seen, 32'hA122_C344);
    endtask

    task automatic t_read_then_write;
        run_op(1'b0, 19'h00123, 32'h0, 4'h0, 2'b00);
        run_op(1'b1, 19'h00124, 32'h0F0F_0F0F, 4'hF, 2'b00);
        chk(contention == 0, "R7", "bus driven during read", contention, 0);
        t_read32(17'h00124, 32'h0F0F_0F0F, "R6");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write32();
        t_read32(17'h00123, 32'hA1B2_C3D4, "R5");
        t_partial32();
        t_mode16();
        t_mode8();
        t_empty_mask();
        t_mode11();
        t_read_then_write();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R2 ready never returned): actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule